// File: doc/BRIEF.md
# Quadratic Evaluator with Sequenced Datapath

This block evaluates the polynomial C·x² + B·x + A on unsigned words of parameterizable width (8 bits by default). It pairs a small register datapath with a controller state machine. After reset is released, the four operands arrive one per clock on a single shared input bus. The controller then runs a fixed schedule of ALU operations. It issues one operation per clock and writes the final value into an output register.

The datapath has four operand registers, one per coefficient and one for x, and a result register. Each register has its own load enable. Two 4-to-1 operand multiplexers feed one ALU, which can only add or multiply. The x and C registers keep their loaded values for the whole run. The A and B registers are reused as scratch storage. When the result has been captured, the block raises a done flag and stays idle until the next reset. Inputs are expected to be small enough that no step exceeds the word width. Any bits above the word width are dropped.

Top module: `quad_eval`

## Requirements
- R1: An active-low asynchronous reset clears every operand register, the result output and the done flag to zero at once, without waiting for a clock edge.
- R2: On the first four rising clock edges after reset is released, the input bus is captured in this fixed order: A on edge 1, B on edge 2, C on edge 3 and x on edge 4.
- R3: The result equals (C·x·x + B·x + A) modulo 2^W, where W is the word width (8 by default).
- R4: Evaluation takes exactly five further clocks, at one ALU operation per clock. Done is low through edge 8 and is high right after edge 9, with the result valid in the same cycle.
- R5: The result output stays zero until it is written on edge 9. No intermediate value ever appears on it.
- R6: The x and C registers hold their loaded values from the edge after they load until reset. Only the A and B registers are overwritten during evaluation.
- R7: Once done is high, done stays high and the result stays unchanged until reset, whatever value is on the input bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | W | Shared operand input bus |
| result | output | W | Registered polynomial value |
| done | output | 1 | Registered flag, high once result is valid |

## Verification
A wrong load order, a wrong multiplexer selection or a clobbered x or C register does not show up until edge 9. It then appears as a wrong result value. The stimulus therefore uses operands that are pairwise distinct, so that a swapped operand or a swapped step changes the final number. A controller that skips a state or adds one shows up as done rising on the wrong edge. The result output, which must stay zero until completion, exposes any early write to the result register in the very cycle it happens.

// File: rtl/quad_pkg.sv
package quad_pkg;
  localparam int NUM_OPND = 4;

  typedef enum logic [1:0] {
    SRC_A = 2'd0,
    SRC_B = 2'd1,
    SRC_C = 2'd2,
    SRC_X = 2'd3
  } src_e;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } op_e;

  typedef struct packed {
    logic [NUM_OPND-1:0] ld;       // per operand register load enable
    logic                ld_res;   // result register load enable
    logic                from_din; // operand source: bus (1) or ALU (0)
    src_e                sel_p;
    src_e                sel_q;
    op_e                 op;
  } ctl_t;
endpackage

// File: rtl/quad_alu.sv
module quad_alu
  import quad_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] p,
  input  logic [W-1:0] q,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_MUL:  y = p * q;
      default: y = p + q;
    endcase
  end
endmodule

// File: rtl/quad_ctrl.sv
module quad_ctrl
  import quad_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output ctl_t ctl,
  output logic done
);
  typedef enum logic [3:0] {
    ST_LD_A, ST_LD_B, ST_LD_C, ST_LD_X,
    ST_BX, ST_ABX, ST_CX, ST_CXX, ST_SUM, ST_IDLE
  } st_e;

  st_e  st_q, st_d;
  logic done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LD_A;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_q | (st_q == ST_SUM);
    end
  end

  always_comb begin
    st_d         = st_q;
    ctl          = '0;
    ctl.sel_p    = SRC_A;
    ctl.sel_q    = SRC_A;
    ctl.op       = OP_ADD;
    unique case (st_q)
      ST_LD_A: begin ctl.ld[SRC_A] = 1'b1; ctl.from_din = 1'b1; st_d = ST_LD_B; end
      ST_LD_B: begin ctl.ld[SRC_B] = 1'b1; ctl.from_din = 1'b1; st_d = ST_LD_C; end
      ST_LD_C: begin ctl.ld[SRC_C] = 1'b1; ctl.from_din = 1'b1; st_d = ST_LD_X; end
      ST_LD_X: begin ctl.ld[SRC_X] = 1'b1; ctl.from_din = 1'b1; st_d = ST_BX;   end
      ST_BX: begin   // B <- B*x
        ctl.ld[SRC_B] = 1'b1; ctl.sel_p = SRC_B; ctl.sel_q = SRC_X; ctl.op = OP_MUL;
        st_d = ST_ABX;
      end
      ST_ABX: begin  // A <- A + B*x
        ctl.ld[SRC_A] = 1'b1; ctl.sel_p = SRC_A; ctl.sel_q = SRC_B; ctl.op = OP_ADD;
        st_d = ST_CX;
      end
      ST_CX: begin   // B <- C*x
        ctl.ld[SRC_B] = 1'b1; ctl.sel_p = SRC_C; ctl.sel_q = SRC_X; ctl.op = OP_MUL;
        st_d = ST_CXX;
      end
      ST_CXX: begin  // B <- C*x*x
        ctl.ld[SRC_B] = 1'b1; ctl.sel_p = SRC_B; ctl.sel_q = SRC_X; ctl.op = OP_MUL;
        st_d = ST_SUM;
      end
      ST_SUM: begin  // result <- C*x*x + (A + B*x)
        ctl.ld_res = 1'b1; ctl.sel_p = SRC_B; ctl.sel_q = SRC_A; ctl.op = OP_ADD;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign done = done_q;
endmodule

// File: rtl/quad_datapath.sv
module quad_datapath
  import quad_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  ctl_t         ctl,
  output logic [W-1:0] result,
  output logic [W-1:0] x_val,
  output logic [W-1:0] c_val
);
  logic [W-1:0] opnd_q [NUM_OPND];
  logic [W-1:0] res_q;
  logic [W-1:0] mux_p, mux_q, alu_y;

  for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          opnd_q[i] <= '0;
      else if (ctl.ld[i])  opnd_q[i] <= ctl.from_din ? din : alu_y;
    end
  end

  assign mux_p = opnd_q[ctl.sel_p];
  assign mux_q = opnd_q[ctl.sel_q];

  quad_alu #(.W(W)) alu_i (
    .op (ctl.op),
    .p  (mux_p),
    .q  (mux_q),
    .y  (alu_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          res_q <= '0;
    else if (ctl.ld_res) res_q <= alu_y;
  end

  assign result = res_q;
  assign x_val  = opnd_q[SRC_X];
  assign c_val  = opnd_q[SRC_C];
endmodule

// File: rtl/quad_eval.sv
module quad_eval
  import quad_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] result,
  output logic         done
);
  ctl_t         ctl;
  logic [W-1:0] x_val, c_val;

  quad_ctrl ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .done  (done)
  );

  quad_datapath #(.W(W)) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .ctl    (ctl),
    .result (result),
    .x_val  (x_val),
    .c_val  (c_val)
  );
endmodule

// File: rtl/quad_eval_chk.sv
module quad_eval_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] result,
  input logic         done,
  input logic [W-1:0] x_val,
  input logic [W-1:0] c_val
);
  localparam int LAT = 9;
  localparam int CW  = $clog2(LAT + 2);
  logic [CW-1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cyc <= '0;
    else if (cyc != CW'(LAT+1)) cyc <= cyc + 1'b1;
  end

  AST_DONE_LATE:    assert property (@(posedge clk) disable iff (!rst_n) (cyc < CW'(LAT)) |-> !done);              // R4
  AST_DONE_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n) (cyc == CW'(LAT)) |-> done);              // R4
  AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !done |-> (result == '0));                // R5
  AST_DONE_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) done |=> done);                           // R7
  AST_RESULT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) done |=> $stable(result));                // R7
  AST_X_KEPT:       assert property (@(posedge clk) disable iff (!rst_n) (cyc >= CW'(4)) |=> $stable(x_val));      // R6
  AST_C_KEPT:       assert property (@(posedge clk) disable iff (!rst_n) (cyc >= CW'(3)) |=> $stable(c_val));      // R6
  AST_RESET_CLEAR:  assert property (@(posedge clk) (cyc == '0) |-> (!done && result == '0));                      // R1
endmodule

bind quad_eval quad_eval_chk #(.W(W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .result (result),
  .done   (done),
  .x_val  (x_val),
  .c_val  (c_val)
);

// File: tb/quad_eval_tb_top.sv
`timescale 1ns/1ps
module quad_eval_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] result;
  logic         done;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q [$];
  logic         seen_done = 1'b0;

  always #2.5 clk = ~clk;

  quad_eval #(.W(W)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .result (result),
    .done   (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on first done of each run
  always @(negedge clk) begin
    if (!rst_n) seen_done <= 1'b0;
    else if (done && !seen_done) begin
      seen_done <= 1'b1;
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected result", int'(result), -1);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(result == e, "R2 R3 R6 result", int'(result), int'(e));
      end
    end
  end

  // Driver: one full evaluation from reset
  task automatic run_vec(input int x, input int a, input int b, input int c);
    logic [W-1:0] ops [4];
    ops[0] = W'(a); ops[1] = W'(b); ops[2] = W'(c); ops[3] = W'(x);
    exp_q.push_back(W'(c * x * x + b * x + a));
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(result == '0, "R1 async clear result", int'(result), 0);
    check(done == 1'b0, "R1 async clear done", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      din = (k <= 4) ? ops[k-1] : W'($urandom);
      @(negedge clk);
      if (k < 9) begin
        check(done == 1'b0, "R4 done early", int'(done), 0);
        check(result == '0, "R5 result early", int'(result), 0);
      end else begin
        check(done == 1'b1, "R4 done after edge 9", int'(done), 1);
      end
    end
    begin
      logic [W-1:0] held;
      held = result;
      for (int k = 0; k < 3; k++) begin
        din = W'($urandom);
        @(negedge clk);
        check(done == 1'b1, "R7 done held", int'(done), 1);
        check(result == held, "R7 result held", int'(result), int'(held));
      end
    end
  endtask

  initial begin
    #1;
    check(result == '0 && done == 1'b0, "R1 reset state", int'(result), 0);
    run_vec(3, 5, 7, 11);      // distinct operands: order errors visible
    run_vec(0, 9, 13, 4);      // x = 0 gives A
    run_vec(0, 0, 0, 0);
    run_vec(15, 30, 0, 1);     // result 255 at the top of the range
    run_vec(1, 2, 3, 4);
    run_vec(2, 40, 1, 15);
    for (int n = 0; n < 20; n++)
      run_vec(int'($urandom_range(0, 3)), int'($urandom_range(0, 40)),
              int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
    @(negedge clk);
    check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule